// File: doc/BRIEF.md
# Planar 4:2:2 Video Capture Address Generator

This block sits between an incoming 4:2:2 pixel stream and a memory write port, and turns each pixel into byte writes spread over three separate planes: one for luma and one for each chroma component. Every input beat carries one luma byte and one chroma byte. The chroma byte belongs to the blue-difference plane on even columns and to the red-difference plane on odd columns, so each chroma line holds half as many samples as the luma line.

Each plane has its own base address and its own line stride. A vertical sync restarts the frame at the base addresses. Each horizontal retrace closes a line and moves each plane's line pointer forward by that plane's stride. Every address is computed when the pixel arrives and is stored with its data in a small per-plane FIFO. When a FIFO is full, the pixel is dropped and the position still advances, so later pixels land at the right place. A single write port with a valid/ready handshake drains the three FIFOs.

Top module: `yuvcap_planar`

## Requirements
- R1: A beat at column x (counted from 0 since the last sync) of line n writes its luma byte to Ybase + (sum of the luma strides applied at the n retraces since the last vertical sync) + x.
- R2: The chroma byte of a beat at an even column goes to the U plane and at an odd column to the V plane, at that plane's line start + floor(x/2).
- R3: Vertical sync reloads all three line starts from the bases and resets the column to 0. Horizontal retrace adds each plane's stride to its line start and resets the column. When both arrive in the same cycle, vertical sync wins.
- R4: The stride used at a retrace is the value on the stride input in the retrace cycle. Changing a stride in the middle of a line does not move any address of that line.
- R5: Bases are sampled only at vertical sync. Changing them during a frame has no effect until the next vertical sync.
- R6: Beats at column ≥ the configured width are not written and do not advance the column.
- R7: `cur_line_o` reads 0 in the cycle after a vertical sync and increments by one in the cycle after each horizontal retrace.
- R8: Each plane FIFO holds FIFO_DEPTH entries. A sample that reaches a full FIFO is discarded, and `ovf_o` is high in exactly the cycle after each such arrival.
- R9: Dropped samples still advance the position, so every later sample is written at its correct address and nothing else is written.
- R10: While `wr_valid_o` is high and `wr_ready_i` is low, valid, address and data hold unchanged in the next cycle.
- R11: After reset, `wr_valid_o`, `ovf_o` and `cur_line_o` are 0.
- R12: When several FIFOs hold data and no transfer is stalled, luma is served before U, and U before V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_i | input | 1 | Frame start pulse |
| hsync_i | input | 1 | Line retrace pulse |
| pix_valid_i | input | 1 | Pixel beat present |
| pix_y_i | input | 8 | Luma byte |
| pix_c_i | input | 8 | Chroma byte (U on even column, V on odd) |
| cfg_width_i | input | 12 | Pixels per line (even, at most 2048) |
| cfg_y_base_i | input | 32 | Luma plane base byte address |
| cfg_u_base_i | input | 32 | U plane base byte address |
| cfg_v_base_i | input | 32 | V plane base byte address |
| cfg_y_stride_i | input | 32 | Luma line stride in bytes |
| cfg_u_stride_i | input | 32 | U line stride in bytes |
| cfg_v_stride_i | input | 32 | V line stride in bytes |
| wr_valid_o | output | 1 | Write request pending |
| wr_ready_i | input | 1 | Memory accepts the write |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 8 | Write byte |
| cur_line_o | output | 11 | Current line number in the frame |
| ovf_o | output | 1 | One-cycle pulse per dropped sample |

## Verification
A wrong column or line-start register shows up as a wrong address on the next accepted write for that plane. Every write is compared with an expected map of address to byte, so the error is caught at that handshake, and a missing write is caught when the map fails to empty. A wrong line counter shows on `cur_line_o` one cycle after the sync that produced it. A wrong FIFO fill level shows as `ovf_o` firing one beat early or late in a stalled line. A grant that switches during a stall shows as a changed address before the handshake completes.

// File: rtl/yuvcap_pkg.sv
package yuvcap_pkg;
  localparam int unsigned AW     = 32;
  localparam int unsigned DW     = 8;
  localparam int unsigned NPLANE = 3;

  typedef enum logic [1:0] {
    PL_Y = 2'd0,
    PL_U = 2'd1,
    PL_V = 2'd2
  } plane_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wbeat_t;
endpackage

// File: rtl/yuvcap_pos_track.sv
module yuvcap_pos_track
  import yuvcap_pkg::*;
#(
  parameter int unsigned MAX_W  = 2048,
  parameter int unsigned LINE_W = 11,
  localparam int unsigned XW    = $clog2(MAX_W) + 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         vsync_i,
  input  logic                         hsync_i,
  input  logic                         pix_valid_i,
  input  logic [DW-1:0]                pix_y_i,
  input  logic [DW-1:0]                pix_c_i,
  input  logic [XW-1:0]                width_i,
  input  logic [NPLANE-1:0][AW-1:0]    base_i,
  input  logic [NPLANE-1:0][AW-1:0]    stride_i,
  output logic [NPLANE-1:0]            push_o,
  output wbeat_t [NPLANE-1:0]          beat_o,
  output logic [LINE_W-1:0]            line_o
);

  logic [XW-1:0]              col_q, col_d;
  logic [LINE_W-1:0]          line_q, line_d;
  logic [NPLANE-1:0][AW-1:0]  start_q, start_d;
  logic                       in_line, take, col_en, line_en;

  assign in_line = (col_q < width_i);
  assign take    = pix_valid_i && in_line;
  assign col_en  = vsync_i || hsync_i || take;
  assign line_en = vsync_i || hsync_i;

  always_comb begin
    col_d   = col_q;
    line_d  = line_q;
    start_d = start_q;
    if (vsync_i) begin
      col_d   = '0;
      line_d  = '0;
      start_d = base_i;
    end else if (hsync_i) begin
      col_d  = '0;
      line_d = line_q + 1'b1;
      for (int p = 0; p < NPLANE; p++) begin
        start_d[p] = start_q[p] + stride_i[p];
      end
    end else if (take) begin
      col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q   <= '0;
      line_q  <= '0;
      start_q <= '0;
    end else begin
      if (col_en)  col_q <= col_d;
      if (line_en) begin
        line_q  <= line_d;
        start_q <= start_d;
      end
    end
  end

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane
    if (p == int'(PL_Y)) begin : g_luma
      assign push_o[p]      = take;
      assign beat_o[p].addr = start_q[p] + AW'(col_q);
      assign beat_o[p].data = pix_y_i;
    end else begin : g_chroma
      localparam logic ODD = (p == int'(PL_V));
      assign push_o[p]      = take && (col_q[0] == ODD);
      assign beat_o[p].addr = start_q[p] + AW'(col_q[XW-1:1]);
      assign beat_o[p].data = pix_c_i;
    end
  end

  assign line_o = line_q;

  AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_i |=> (line_o == '0)); // R7
  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync_i && !vsync_i) |=> (line_o == $past(line_o) + 1'b1)); // R7
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid_i && !hsync_i && !vsync_i) |=> $stable(beat_o[0].addr)); // R1

endmodule

// File: rtl/yuvcap_sfifo.sv
module yuvcap_sfifo
  import yuvcap_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push_i,
  input  wbeat_t din_i,
  input  logic   pop_i,
  output wbeat_t dout_o,
  output logic   nempty_o,
  output logic   drop_o
);

  wbeat_t          mem_q [DEPTH];
  logic [PW-1:0]   wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            full, do_push, do_pop;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign nempty_o = (cnt_q != '0);
  assign do_push  = push_i && !full;
  assign do_pop   = pop_i && nempty_o;
  assign drop_o   = push_i && full;

  always_comb begin
    wp_d  = do_push ? ptr_inc(wp_q) : wp_q;
    rp_d  = do_pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_d;
      if (do_pop)  rp_q <= rp_d;
      if (do_push || do_pop) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= din_i;
  end

  assign dout_o = mem_q[rp_q];

  AST_DROP_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> (cnt_q == $past(cnt_q) - CW'($past(pop_i)))); // R8

endmodule

// File: rtl/yuvcap_wr_arb.sv
module yuvcap_wr_arb
  import yuvcap_pkg::*;
#(
  parameter int unsigned N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  wbeat_t [N-1:0] beat_i,
  input  logic          ready_i,
  output logic          valid_o,
  output wbeat_t        beat_o,
  output logic [N-1:0]  pop_o
);

  logic [N-1:0] pick, gnt, hold_gnt_q;
  logic         hold_q, hold_d;

  always_comb begin
    logic found;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  assign gnt     = hold_q ? hold_gnt_q : pick;
  assign valid_o = |req_i;
  assign pop_o   = gnt & req_i & {N{ready_i}};
  assign hold_d  = valid_o && !ready_i;

  always_comb begin
    beat_o = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) beat_o = beat_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      hold_gnt_q <= '0;
    end else begin
      hold_q <= hold_d;
      if (hold_d) hold_gnt_q <= gnt;
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R12
  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (gnt == $past(gnt))); // R10

endmodule

// File: rtl/yuvcap_planar.sv
module yuvcap_planar
  import yuvcap_pkg::*;
#(
  parameter int unsigned MAX_W      = 2048,
  parameter int unsigned LINE_W     = 11,
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned XW        = $clog2(MAX_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_i,
  input  logic              hsync_i,
  input  logic              pix_valid_i,
  input  logic [DW-1:0]     pix_y_i,
  input  logic [DW-1:0]     pix_c_i,
  input  logic [XW-1:0]     cfg_width_i,
  input  logic [AW-1:0]     cfg_y_base_i,
  input  logic [AW-1:0]     cfg_u_base_i,
  input  logic [AW-1:0]     cfg_v_base_i,
  input  logic [AW-1:0]     cfg_y_stride_i,
  input  logic [AW-1:0]     cfg_u_stride_i,
  input  logic [AW-1:0]     cfg_v_stride_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [AW-1:0]     wr_addr_o,
  output logic [DW-1:0]     wr_data_o,
  output logic [LINE_W-1:0] cur_line_o,
  output logic              ovf_o
);

  logic [1:0]                rs_q;
  logic                      rst_sync_n;
  logic [NPLANE-1:0][AW-1:0] base_v, stride_v;
  logic [NPLANE-1:0]         push, nempty, drop, pop;
  wbeat_t [NPLANE-1:0]       in_beat, out_beat;
  wbeat_t                    wr_beat;
  logic                      ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign base_v   = {cfg_v_base_i,   cfg_u_base_i,   cfg_y_base_i};
  assign stride_v = {cfg_v_stride_i, cfg_u_stride_i, cfg_y_stride_i};

  yuvcap_pos_track #(
    .MAX_W  (MAX_W),
    .LINE_W (LINE_W)
  ) pos_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .vsync_i     (vsync_i),
    .hsync_i     (hsync_i),
    .pix_valid_i (pix_valid_i),
    .pix_y_i     (pix_y_i),
    .pix_c_i     (pix_c_i),
    .width_i     (cfg_width_i),
    .base_i      (base_v),
    .stride_i    (stride_v),
    .push_o      (push),
    .beat_o      (in_beat),
    .line_o      (cur_line_o)
  );

  for (genvar p = 0; p < NPLANE; p++) begin : g_fifo
    yuvcap_sfifo #(
      .DEPTH (FIFO_DEPTH)
    ) fifo_i (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .push_i   (push[p]),
      .din_i    (in_beat[p]),
      .pop_i    (pop[p]),
      .dout_o   (out_beat[p]),
      .nempty_o (nempty[p]),
      .drop_o   (drop[p])
    );
  end

  yuvcap_wr_arb #(
    .N (NPLANE)
  ) arb_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req_i   (nempty),
    .beat_i  (out_beat),
    .ready_i (wr_ready_i),
    .valid_o (wr_valid_o),
    .beat_o  (wr_beat),
    .pop_o   (pop)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ovf_q <= 1'b0;
    else             ovf_q <= |drop;
  end

  assign ovf_o     = ovf_q;
  assign wr_addr_o = wr_beat.addr;
  assign wr_data_o = wr_beat.data;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_valid_o && !wr_ready_i) |=>
      (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R10

endmodule

// File: tb/yuvcap_planar_tb_top.sv
`timescale 1ns/1ps
module yuvcap_planar_tb_top;

  logic        clk;
  logic        rst_n;
  logic        vsync, hsync, pix_valid;
  logic [7:0]  pix_y, pix_c;
  logic [11:0] cfg_width;
  logic [31:0] ybase, ubase, vbase, ystr, ustr, vstr;
  logic        wr_valid, wr_ready;
  logic [31:0] wr_addr;
  logic [7:0]  wr_data;
  logic [10:0] cur_line;
  logic        ovf;

  yuvcap_planar dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .vsync_i        (vsync),
    .hsync_i        (hsync),
    .pix_valid_i    (pix_valid),
    .pix_y_i        (pix_y),
    .pix_c_i        (pix_c),
    .cfg_width_i    (cfg_width),
    .cfg_y_base_i   (ybase),
    .cfg_u_base_i   (ubase),
    .cfg_v_base_i   (vbase),
    .cfg_y_stride_i (ystr),
    .cfg_u_stride_i (ustr),
    .cfg_v_stride_i (vstr),
    .wr_valid_o     (wr_valid),
    .wr_ready_i     (wr_ready),
    .wr_addr_o      (wr_addr),
    .wr_data_o      (wr_data),
    .cur_line_o     (cur_line),
    .ovf_o          (ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int          n_chk = 0;
  int          n_err = 0;
  int          cyc   = 0;
  logic        rdy_en = 1'b0;
  logic [7:0]  exp_mem [int unsigned];
  int unsigned m_start [3];
  int          m_x, m_line, seed;
  logic        first_pending = 1'b0;
  int unsigned first_exp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ready pattern and watchdog
  initial begin
    wr_ready = 1'b0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      wr_ready = rdy_en && ((cyc % 3) != 0);
      if (cyc > 150000) begin
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  // write monitor, sampled at the falling edge
  initial begin
    logic        prev_stall;
    logic [31:0] prev_addr;
    logic [7:0]  prev_data;
    prev_stall = 1'b0;
    prev_addr  = '0;
    prev_data  = '0;
    forever begin
      @(negedge clk);
      if (prev_stall)
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data,
            "R10", "stalled write changed", {wr_addr, wr_data}, {prev_addr, prev_data});
      if (wr_valid && wr_ready) begin
        if (first_pending) begin
          chk(wr_addr == first_exp, "R12", "first write after release", wr_addr, first_exp);
          first_pending = 1'b0;
        end
        if (exp_mem.exists(wr_addr)) begin
          chk(exp_mem[wr_addr] == wr_data, "R1,R2", "data at address", wr_data, exp_mem[wr_addr]);
          exp_mem.delete(wr_addr);
        end else begin
          chk(1'b0, "R1,R2,R6,R9", "unexpected write address", wr_addr, 0);
        end
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;
    end
  end

  function automatic logic [7:0] ydat();
    return 8'((m_line * 13 + m_x * 7 + seed) & 255);
  endfunction
  function automatic logic [7:0] cdat();
    return 8'((m_line * 29 + m_x * 5 + seed * 3 + 64) & 255);
  endfunction

  // model: record expected writes for the beat at m_x, then advance
  task automatic model_beat(input bit drop_y, input bit drop_c);
    if (m_x < int'(cfg_width)) begin
      if (!drop_y) exp_mem[m_start[0] + m_x] = pix_y;
      if (!drop_c) exp_mem[m_start[1 + (m_x % 2)] + m_x / 2] = pix_c;
      m_x++;
    end
  endtask

  task automatic send(input int count);
    for (int k = 0; k < count; k++) begin
      @(posedge clk); #1;
      pix_valid = 1'b1;
      pix_y = ydat();
      pix_c = cdat();
      model_beat(1'b0, 1'b0);
      @(posedge clk); #1;
      pix_valid = 1'b0;
      repeat (2) @(posedge clk);
    end
  endtask

  task automatic do_vsync(input bit with_h);
    @(posedge clk); #1;
    vsync = 1'b1;
    hsync = with_h;
    m_start[0] = ybase; m_start[1] = ubase; m_start[2] = vbase;
    m_line = 0; m_x = 0;
    @(posedge clk); #1;
    vsync = 1'b0; hsync = 1'b0;
    @(negedge clk);
    if (with_h) chk(cur_line == 0, "R3", "line after joint syncs", cur_line, 0);
    else        chk(cur_line == 0, "R7", "line after vsync", cur_line, 0);
  endtask

  task automatic do_hsync();
    @(posedge clk); #1;
    hsync = 1'b1;
    m_start[0] += ystr; m_start[1] += ustr; m_start[2] += vstr;
    m_line++; m_x = 0;
    @(posedge clk); #1;
    hsync = 1'b0;
    @(negedge clk);
    chk(cur_line == 11'(m_line), "R7", "line after retrace", cur_line, m_line);
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && exp_mem.num() != 0; i++) @(posedge clk);
    repeat (6) @(posedge clk);
    chk(exp_mem.num() == 0, req, "writes still missing", exp_mem.num(), 0);
  endtask

  task automatic set_cfg(input int w, input int unsigned yb, input int unsigned ub,
                         input int unsigned vb, input int unsigned ys,
                         input int unsigned us, input int unsigned vs);
    cfg_width = 12'(w);
    ybase = yb; ubase = ub; vbase = vb;
    ystr = ys; ustr = us; vstr = vs;
  endtask

  initial begin
    rst_n = 1'b0; vsync = 1'b0; hsync = 1'b0; pix_valid = 1'b0;
    pix_y = '0; pix_c = '0; seed = 0; m_x = 0; m_line = 0; first_exp = 0;
    m_start[0] = 0; m_start[1] = 0; m_start[2] = 0;
    set_cfg(4, 32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 16, 8, 8);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11: idle outputs after reset
    chk(wr_valid == 1'b0, "R11", "wr_valid after reset", wr_valid, 0);
    chk(ovf == 1'b0, "R11", "ovf after reset", ovf, 0);
    chk(cur_line == 0, "R11", "cur_line after reset", cur_line, 0);
    rdy_en = 1'b1;

    // sweep of widths and strides; R1 R2 R3 by address match
    for (int c = 0; c < 3; c++) begin
      int w;
      w = (c == 0) ? 4 : (c == 1) ? 10 : 16;
      seed = c * 17 + 1;
      set_cfg(w, 32'h1000_0000 + c * 32'h10_0000, 32'h2000_0000 + c * 32'h10_0000,
              32'h3000_0000 + c * 32'h10_0000, w + 8 * c, w / 2 + 3, w / 2 + 64 * (c + 1));
      do_vsync(1'b0);
      for (int ln = 0; ln < 4; ln++) begin
        if (c == 1 && ln == 2) begin
          send(w + 3);                       // R6: beats past the line end
          drain("R6");
        end else if (c == 2 && ln == 1) begin
          send(w / 2);
          ystr = 32'h200; ustr = 32'h101; vstr = 32'h77;   // R4: mid-line change
          send(w - w / 2);
          drain("R4");
        end else if (c == 2 && ln == 2) begin
          ybase = 32'h5000_0000; ubase = 32'h6000_0000; vbase = 32'h7000_0000; // R5
          send(w);
          drain("R5");
        end else begin
          send(w);
        end
        do_hsync();
      end
      drain("R1,R2");
    end

    // R5: new bases take effect at the next vsync
    seed = 90;
    do_vsync(1'b0);
    send(16);
    do_hsync();
    send(16);
    drain("R5");

    // R3: joint vsync and retrace restart the frame at the bases
    send(6);
    do_vsync(1'b1);
    send(16);
    drain("R3");

    // R8 R9 R12: stalled port, overflow pattern, recovery
    drain("R9");
    rdy_en = 1'b0;
    repeat (3) @(posedge clk);
    set_cfg(24, 32'h0800_0000, 32'h0900_0000, 32'h0A00_0000, 40, 20, 24);
    seed = 55;
    do_vsync(1'b0);
    first_exp = m_start[0];
    for (int k = 0; k < 24; k++) begin
      bit eo;
      eo = (m_x >= 8);
      @(posedge clk); #1;
      pix_valid = 1'b1;
      pix_y = ydat();
      pix_c = cdat();
      model_beat(m_x >= 8, m_x >= 16);
      @(posedge clk); #1;
      pix_valid = 1'b0;
      @(negedge clk);
      chk(ovf == eo, "R8", "overflow pulse", ovf, eo);
    end
    @(negedge clk);
    chk(ovf == 1'b0, "R8", "overflow after last beat", ovf, 0);
    first_pending = 1'b1;
    rdy_en = 1'b1;
    drain("R12");
    do_hsync();
    send(24);
    do_hsync();
    send(24);
    drain("R9");

    finish_run();
  end

endmodule